// File: doc/BRIEF.md
# Asynchronous DRAM pin-level control decoder

This block models the memory side of an asynchronous DRAM interface. A fast oversampling clock samples the active-low strobes (row strobe, column strobe, write enable, output enable), the address pins and the input half of the data bus. From the relative order of strobe edges it works out what kind of cycle the controller is running. The kinds are: read, early write, late write, read-modify-write, row-only refresh, column-before-row refresh, and hidden refresh. It latches the row and column addresses and reads or writes a small cell array that keeps only the low bits of each address. It drives the output data with extended-data-out hold.

An internal refresh counter supplies the row for the refresh kinds that do not use the address pins. The bidirectional data bus is split into `dq_in`, `dq_out` and the drive enable `dq_oe`. A pad ring combines them. Each row-strobe low period produces one report when the row strobe returns high. The report gives the cycle kind on `kind_out` and the row that was opened or refreshed on `act_row`.

The pin side is a strobe protocol, not a stream. The decoder cannot stall the controller, so there is no valid/ready pair and no back-pressure. A controller must hold each pin level for at least two clock cycles so that every edge is seen.

Top module: `dram_pin_decoder`

## Requirements
- R1: A falling row strobe with the column strobe high latches the address as the row. A falling column strobe then latches the address as the column. With write enable high, a read returns the cell at index {row[2:0], col[2:0]} on `dq_out`, and `dq_oe` is 1 while output enable is low.
- R2: If write enable is low when the column strobe falls, the cycle is an early write. `dq_in` is sampled at the column strobe fall and stored, `dq_oe` stays 0, and the report kind is 2.
- R3: If write enable falls while a read access is open and output enable stayed high through that access, the cycle is a late write. `dq_in` is sampled at the write enable fall and stored, `dq_oe` stays 0, and the report kind is 3.
- R4: If output enable was low during the read access before write enable falls, the cycle is a read-modify-write. The old data is driven first, the new data is stored at the write enable fall, and the report kind is 4.
- R5: During a read, output enable high turns `dq_oe` off. Output enable low again turns it back on with the same data.
- R6: With the row strobe held low, the read data and `dq_oe` stay valid after the column strobe rises. They change only when the next column strobe fall loads new data.
- R7: Once both the row strobe and the column strobe are high, `dq_oe` is 0.
- R8: A row strobe fall while the column strobe is low is a column-before-row refresh. The address, write enable and data pins are ignored, the cell array is not written, and the report kind is 6. `act_row` is the refresh counter value, which then advances by one and wraps from 2047 to 0.
- R9: If the row strobe falls again with the column strobe still low after a read, the cycle is a hidden refresh. `dq_out` and `dq_oe` keep the read data, the report kind is 7, and `act_row` and the counter behave as in R8.
- R10: A row strobe low period with no column strobe activity is a row-only refresh. It reports kind 5 with the latched row on `act_row`, leaves the cells unchanged and keeps `dq_oe` at 0.
- R11: Each row strobe low period produces exactly one one-cycle `kind_stb` pulse, issued after the row strobe returns high. For page cycles the kind is that of the last column access; read is kind 1.
- R12: After reset, `dq_oe`, `kind_stb`, `kind_out`, `act_row` and the refresh counter are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_in | input | DQ_W | Data from the bus |
| dq_out | output | DQ_W | Data to the bus |
| dq_oe | output | 1 | Drive enable for dq_out |
| kind_stb | output | 1 | One-cycle pulse when a row strobe period ends |
| kind_out | output | 3 | Kind of the last reported period |
| act_row | output | ADDR_W | Row opened or refreshed in the last reported period |

## Verification
The write kinds are told apart only by where write enable falls relative to the column strobe, and by whether output enable was low before that point. So the bench runs the same row and column through early, late and read-modify-write orderings, then reads each result back. Refresh classification is tested three ways: a row strobe with no column activity, a column strobe that is already low at the row strobe fall with a clean bus, and a column strobe that is still low after a read. This separates row-only, column-before-row and hidden refresh, and shows the held data surviving only in the last case. Page reads with two columns show data holding across the column strobe precharge. A run of more than 2048 refreshes exercises the counter wrap.

// File: rtl/dram_dec_pkg.sv
package dram_dec_pkg;
  typedef enum logic [2:0] {
    KIND_NONE     = 3'd0,
    KIND_READ     = 3'd1,
    KIND_EARLY_WR = 3'd2,
    KIND_LATE_WR  = 3'd3,
    KIND_RMW      = 3'd4,
    KIND_RAS_ONLY = 3'd5,
    KIND_CBR      = 3'd6,
    KIND_HIDDEN   = 3'd7
  } cyc_kind_e;

  localparam int NSTB    = 4;
  localparam int STB_RAS = 0;
  localparam int STB_CAS = 1;
  localparam int STB_WE  = 2;
  localparam int STB_OE  = 3;
endpackage

// File: rtl/dram_pin_sampler.sv
module dram_pin_sampler import dram_dec_pkg::*; #(
  parameter int ADDR_W = 11,
  parameter int DQ_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSTB-1:0]   strb_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DQ_W-1:0]   dq_in,
  output logic [NSTB-1:0]   lvl,
  output logic [NSTB-1:0]   fall,
  output logic [NSTB-1:0]   rise,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DQ_W-1:0]   dq_q
);
  logic [NSTB-1:0] s_q, s_qq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_q    <= '1;
      s_qq   <= '1;
      addr_q <= '0;
      dq_q   <= '0;
    end else begin
      s_q    <= strb_n;
      s_qq   <= s_q;
      addr_q <= addr;
      dq_q   <= dq_in;
    end
  end

  assign lvl = s_q;

  for (genvar i = 0; i < NSTB; i++) begin : g_edge
    assign fall[i] = s_qq[i] & ~s_q[i];
    assign rise[i] = ~s_qq[i] & s_q[i];
  end
endmodule

// File: rtl/dram_refresh_ctr.sv
module dram_refresh_ctr #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] value
);
  always_ff @(posedge clk) begin
    if (!rst_n) value <= '0;
    else if (inc) value <= value + W'(1);
  end

  assert_ctr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> (value == $past(value) + W'(1)));

  assert_ctr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(value));
endmodule

// File: rtl/dram_cell_array.sv
module dram_cell_array #(
  parameter int AW = 6,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[idx] <= wdata;
  end

  assign rdata = cells[idx];
endmodule

// File: rtl/dram_pin_decoder.sv
module dram_pin_decoder import dram_dec_pkg::*; #(
  parameter int ADDR_W   = 11,
  parameter int DQ_W     = 4,
  parameter int ROW_KEEP = 3,
  parameter int COL_KEEP = 3,
  parameter int REF_W    = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DQ_W-1:0]   dq_in,
  output logic [DQ_W-1:0]   dq_out,
  output logic              dq_oe,
  output logic              kind_stb,
  output logic [2:0]        kind_out,
  output logic [ADDR_W-1:0] act_row
);
  localparam int CELL_AW = ROW_KEEP + COL_KEEP;

  logic [NSTB-1:0]   lvl, fall, rise;
  logic [ADDR_W-1:0] addr_q;
  logic [DQ_W-1:0]   dq_q;

  dram_pin_sampler #(.ADDR_W(ADDR_W), .DQ_W(DQ_W)) u_sampler (
    .clk    (clk),
    .rst_n  (rst_n),
    .strb_n ({oe_n, we_n, cas_n, ras_n}),
    .addr   (addr),
    .dq_in  (dq_in),
    .lvl    (lvl),
    .fall   (fall),
    .rise   (rise),
    .addr_q (addr_q),
    .dq_q   (dq_q)
  );

  logic unused_edges;
  assign unused_edges = ^{rise[STB_WE], rise[STB_OE], fall[STB_OE]};

  // period state
  logic              ras_open;   // a row strobe low period is in progress
  logic              refr;       // that period is a counter-driven refresh
  logic              hid;        // refresh started with read data held
  logic [ADDR_W-1:0] row_q;
  logic [COL_KEEP-1:0] col_q;
  cyc_kind_e         acc_kind;   // kind of the latest column access
  logic              acc_open;   // column strobe low inside a normal period
  logic              oe_seen;    // output enable was low during the read
  logic [DQ_W-1:0]   dout_q;
  logic              dvalid;
  logic              kind_stb_q;
  logic [2:0]        kind_q;
  logic [ADDR_W-1:0] act_row_q;

  // refresh counter
  logic [REF_W-1:0] ref_val;
  logic             ctr_inc;

  assign ctr_inc = rise[STB_RAS] && ras_open && refr;

  dram_refresh_ctr #(.W(REF_W)) u_refresh (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (ctr_inc),
    .value (ref_val)
  );

  // cell access decode
  logic                access_hit, early_hit, late_hit, cell_we;
  logic [COL_KEEP-1:0] col_sel;
  logic [CELL_AW-1:0]  cell_idx;
  logic [DQ_W-1:0]     cell_rdata;

  always_comb begin
    access_hit = fall[STB_CAS] && ras_open && !refr && !fall[STB_RAS];
    early_hit  = access_hit && !lvl[STB_WE];
    late_hit   = fall[STB_WE] && acc_open && (acc_kind == KIND_READ) && !fall[STB_CAS];
    cell_we    = early_hit || late_hit;
    col_sel    = fall[STB_CAS] ? addr_q[COL_KEEP-1:0] : col_q;
    cell_idx   = {row_q[ROW_KEEP-1:0], col_sel};
  end

  dram_cell_array #(.AW(CELL_AW), .DW(DQ_W)) u_cells (
    .clk   (clk),
    .we    (cell_we),
    .idx   (cell_idx),
    .wdata (dq_q),
    .rdata (cell_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_open   <= 1'b0;
      refr       <= 1'b0;
      hid        <= 1'b0;
      row_q      <= '0;
      col_q      <= '0;
      acc_kind   <= KIND_NONE;
      acc_open   <= 1'b0;
      oe_seen    <= 1'b0;
      dout_q     <= '0;
      dvalid     <= 1'b0;
      kind_stb_q <= 1'b0;
      kind_q     <= 3'd0;
      act_row_q  <= '0;
    end else begin
      kind_stb_q <= 1'b0;

      // row strobe: open or close a period
      if (fall[STB_RAS]) begin
        ras_open <= 1'b1;
        acc_kind <= KIND_NONE;
        acc_open <= 1'b0;
        if (!lvl[STB_CAS]) begin
          refr  <= 1'b1;
          hid   <= dvalid;
          row_q <= ADDR_W'(ref_val);
        end else begin
          refr  <= 1'b0;
          hid   <= 1'b0;
          row_q <= addr_q;
        end
      end else if (rise[STB_RAS] && ras_open) begin
        ras_open   <= 1'b0;
        acc_open   <= 1'b0;
        refr       <= 1'b0;
        kind_stb_q <= 1'b1;
        act_row_q  <= row_q;
        if (refr)                       kind_q <= hid ? KIND_HIDDEN : KIND_CBR;
        else if (acc_kind == KIND_NONE) kind_q <= KIND_RAS_ONLY;
        else                            kind_q <= acc_kind;
      end

      // output enable history of an open read
      if (acc_open && (acc_kind == KIND_READ) && !lvl[STB_OE]) oe_seen <= 1'b1;

      // column access
      if (access_hit) begin
        col_q    <= addr_q[COL_KEEP-1:0];
        acc_open <= 1'b1;
        if (!lvl[STB_WE]) begin
          acc_kind <= KIND_EARLY_WR;
          dvalid   <= 1'b0;
        end else begin
          acc_kind <= KIND_READ;
          dout_q   <= cell_rdata;
          dvalid   <= 1'b1;
          oe_seen  <= !lvl[STB_OE];
        end
      end

      // write enable after the column strobe
      if (late_hit) begin
        acc_kind <= oe_seen ? KIND_RMW : KIND_LATE_WR;
        dvalid   <= 1'b0;
      end

      // column strobe precharge ends the access; data is held
      if (rise[STB_CAS] && !rise[STB_RAS]) acc_open <= 1'b0;

      // both strobes high: outputs released
      if (lvl[STB_RAS] && lvl[STB_CAS]) dvalid <= 1'b0;
    end
  end

  assign dq_out   = dout_q;
  assign dq_oe    = dvalid && !lvl[STB_OE] && lvl[STB_WE];
  assign kind_stb = kind_stb_q;
  assign kind_out = kind_q;
  assign act_row  = act_row_q;

  assert_early_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_open && acc_kind == KIND_EARLY_WR) |-> !dq_oe);

  assert_idle_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl[STB_RAS] && lvl[STB_CAS]) |=> !dq_oe);

  assert_refresh_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_open && refr) |-> !cell_we);

  assert_hidden_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_open && refr && hid) |=> $stable(dout_q));

  assert_report_kind_R11: assert property (@(posedge clk) disable iff (!rst_n)
    kind_stb |-> (kind_out != 3'd0));
endmodule

// File: tb/tb_dram_pin_decoder.sv
module tb_dram_pin_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [10:0] addr = '0;
  logic [3:0]  dq_in = '0;
  logic [3:0]  dq_out;
  logic        dq_oe, kind_stb;
  logic [2:0]  kind_out;
  logic [10:0] act_row;

  int checks = 0, failures = 0, stb_cnt = 0;
  logic [3:0]  mdl [64];
  logic [10:0] ref_exp = '0;
  bit          done = 1'b0;

  dram_pin_decoder dut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
    .kind_stb(kind_stb), .kind_out(kind_out), .act_row(act_row)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (rst_n && kind_stb) stb_cnt++;

  function automatic int idx(input logic [10:0] r, input logic [10:0] c);
    return int'({r[2:0], c[2:0]});
  endfunction

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic end_period(input int ek, input logic [10:0] er, input int s0, input string req);
    chk(kind_out == 3'(ek), req, int'(kind_out), ek);
    chk(act_row == er, req, int'(act_row), int'(er));
    chk(stb_cnt == s0 + 1, "R11", stb_cnt, s0 + 1);
  endtask

  task automatic t_reset();
    chk(dq_oe == 1'b0, "R12", int'(dq_oe), 0);
    chk(kind_out == 3'd0, "R12", int'(kind_out), 0);
    chk(act_row == 11'd0, "R12", int'(act_row), 0);
    chk(stb_cnt == 0, "R12", stb_cnt, 0);
  endtask

  task automatic t_early_write(input logic [10:0] r, input logic [10:0] c, input logic [3:0] d);
    int s0 = stb_cnt;
    addr = r; ras_n = 1'b0; settle();
    addr = c; dq_in = d; we_n = 1'b0; settle();
    cas_n = 1'b0; settle();
    chk(dq_oe == 1'b0, "R2", int'(dq_oe), 0);
    cas_n = 1'b1; settle();
    we_n = 1'b1; ras_n = 1'b1; settle();
    end_period(2, r, s0, "R2");
    mdl[idx(r, c)] = d;
  endtask

  task automatic t_read(input logic [10:0] r, input logic [10:0] c, input string req);
    int s0 = stb_cnt;
    logic [3:0] e = mdl[idx(r, c)];
    addr = r; ras_n = 1'b0; settle();
    addr = c; oe_n = 1'b0; settle();
    cas_n = 1'b0; settle();
    chk(dq_oe == 1'b1, "R1", int'(dq_oe), 1);
    chk(dq_out == e, req, int'(dq_out), int'(e));
    oe_n = 1'b1; settle();
    chk(dq_oe == 1'b0, "R5", int'(dq_oe), 0);
    oe_n = 1'b0; settle();
    chk(dq_oe == 1'b1 && dq_out == e, "R5", int'(dq_out), int'(e));
    cas_n = 1'b1; settle();
    chk(dq_oe == 1'b1, "R6", int'(dq_oe), 1);
    chk(dq_out == e, "R6", int'(dq_out), int'(e));
    ras_n = 1'b1; settle();
    chk(dq_oe == 1'b0, "R7", int'(dq_oe), 0);
    oe_n = 1'b1;
    end_period(1, r, s0, "R1");
  endtask

  task automatic t_page(input logic [10:0] r, input logic [10:0] c1, input logic [10:0] c2);
    int s0 = stb_cnt;
    logic [3:0] e1 = mdl[idx(r, c1)];
    logic [3:0] e2 = mdl[idx(r, c2)];
    addr = r; ras_n = 1'b0; settle();
    addr = c1; oe_n = 1'b0; cas_n = 1'b0; settle();
    chk(dq_out == e1, "R6", int'(dq_out), int'(e1));
    cas_n = 1'b1; addr = c2; settle();
    chk(dq_oe == 1'b1 && dq_out == e1, "R6", int'(dq_out), int'(e1));
    cas_n = 1'b0; settle();
    chk(dq_oe == 1'b1 && dq_out == e2, "R6", int'(dq_out), int'(e2));
    cas_n = 1'b1; ras_n = 1'b1; settle();
    oe_n = 1'b1;
    end_period(1, r, s0, "R11");
  endtask

  task automatic t_late_write(input logic [10:0] r, input logic [10:0] c, input logic [3:0] d);
    int s0 = stb_cnt;
    oe_n = 1'b1;
    addr = r; ras_n = 1'b0; settle();
    addr = c; cas_n = 1'b0; settle();
    chk(dq_oe == 1'b0, "R3", int'(dq_oe), 0);
    dq_in = d; we_n = 1'b0; settle();
    chk(dq_oe == 1'b0, "R3", int'(dq_oe), 0);
    we_n = 1'b1; cas_n = 1'b1; settle();
    ras_n = 1'b1; settle();
    end_period(3, r, s0, "R3");
    mdl[idx(r, c)] = d;
  endtask

  task automatic t_rmw(input logic [10:0] r, input logic [10:0] c, input logic [3:0] d);
    int s0 = stb_cnt;
    logic [3:0] e = mdl[idx(r, c)];
    addr = r; ras_n = 1'b0; settle();
    addr = c; oe_n = 1'b0; cas_n = 1'b0; settle();
    chk(dq_oe == 1'b1 && dq_out == e, "R4", int'(dq_out), int'(e));
    oe_n = 1'b1; settle();
    dq_in = d; we_n = 1'b0; settle();
    chk(dq_oe == 1'b0, "R4", int'(dq_oe), 0);
    we_n = 1'b1; cas_n = 1'b1; settle();
    ras_n = 1'b1; settle();
    end_period(4, r, s0, "R4");
    mdl[idx(r, c)] = d;
  endtask

  task automatic t_ras_only(input logic [10:0] r);
    int s0 = stb_cnt;
    addr = r; ras_n = 1'b0; settle();
    chk(dq_oe == 1'b0, "R10", int'(dq_oe), 0);
    ras_n = 1'b1; settle();
    end_period(5, r, s0, "R10");
  endtask

  task automatic t_cbr(input logic [10:0] junk);
    int s0 = stb_cnt;
    cas_n = 1'b0; settle();
    addr = junk; we_n = 1'b0; dq_in = ~junk[3:0]; ras_n = 1'b0; settle();
    chk(dq_oe == 1'b0, "R8", int'(dq_oe), 0);
    ras_n = 1'b1; settle();
    end_period(6, ref_exp, s0, "R8");
    ref_exp = ref_exp + 11'd1;
    we_n = 1'b1; cas_n = 1'b1; settle();
  endtask

  task automatic t_hidden(input logic [10:0] r, input logic [10:0] c);
    int s0 = stb_cnt;
    int s1;
    logic [3:0] e = mdl[idx(r, c)];
    addr = r; ras_n = 1'b0; settle();
    addr = c; oe_n = 1'b0; cas_n = 1'b0; settle();
    chk(dq_out == e, "R1", int'(dq_out), int'(e));
    ras_n = 1'b1; settle();
    end_period(1, r, s0, "R11");
    chk(dq_oe == 1'b1 && dq_out == e, "R9", int'(dq_out), int'(e));
    s1 = stb_cnt;
    addr = 11'h5A5; ras_n = 1'b0; settle();
    chk(dq_oe == 1'b1 && dq_out == e, "R9", int'(dq_out), int'(e));
    ras_n = 1'b1; settle();
    end_period(7, ref_exp, s1, "R9");
    ref_exp = ref_exp + 11'd1;
    cas_n = 1'b1; settle();
    chk(dq_oe == 1'b0, "R7", int'(dq_oe), 0);
    oe_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    t_reset();

    t_early_write(11'h101, 11'h003, 4'hA);
    t_early_write(11'h102, 11'h004, 4'h5);
    t_early_write(11'h101, 11'h006, 4'h3);
    t_read(11'h101, 11'h003, "R2");
    t_read(11'h102, 11'h004, "R2");
    t_page(11'h101, 11'h003, 11'h006);

    t_late_write(11'h102, 11'h004, 4'hC);
    t_read(11'h102, 11'h004, "R3");
    t_rmw(11'h101, 11'h003, 4'h9);
    t_read(11'h101, 11'h003, "R4");

    t_ras_only(11'h101);
    t_read(11'h101, 11'h006, "R10");

    t_cbr(11'h0C3);
    t_cbr(11'h101);
    t_read(11'h101, 11'h003, "R8");
    t_read(11'h101, 11'h006, "R8");

    t_hidden(11'h102, 11'h004);

    // run the refresh counter through its wrap
    for (int k = 0; k < 2048; k++) t_cbr(11'(k));
    chk(ref_exp == 11'd3, "R8", int'(ref_exp), 3);
    t_read(11'h102, 11'h004, "R8");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule